// File: doc/BRIEF.md
# Reserved Counter-Rotating Ring Interconnect

This block joins a fixed set of nodes (four by default) with four parallel rings of 128-bit words. Rings with an even index carry words from node n to node n+1. Rings with an odd index carry them from node n to node n-1, wrapping modulo the node count. Every node owns one register stage per ring. A word therefore advances exactly one node per clock and passes intermediate nodes unchanged.

A central controller takes transfer requests from the nodes. Each request names a destination and a beat count. The controller picks a ring whose every path segment is free and books those segments, together with the destination's off-ramp, for the whole transfer. It then signals the source, which feeds one beat per cycle into its on-ramp. Words tagged for a node are pulled off at that node's off-ramp and leave the ring there. Because the segments are booked in advance, a granted transfer always has its bandwidth and never collides with other traffic.

A source holds its request until it sees its grant pulse. The request is accepted in the grant cycle.

Top module: `quad_ring_fabric`

## Requirements
- R1: While reset is asserted, and right after it, no grant, no on-ramp take and no off-ramp output is active, all ring stages are empty, and every booking is cleared, so that the first legal request after reset is granted in the cycle it is presented.
- R2: Ring r carries words from node n to node (n+1) mod N when r is even, and to node (n-1+N) mod N when r is odd. A beat taken by the on-ramp of the source in cycle t appears at the off-ramp of the destination in cycle t+h, where h is the hop count along the granted ring.
- R3: The grant is a one-hot pulse on `grant` (bit = source node), combinational in the cycle of acceptance. At most one grant is issued per cycle. The length field holds beats minus one, so 0 means 1 beat and 15 means 16 beats. `inj_take` of the source is high for exactly that many consecutive cycles, starting the cycle after the grant, and one word of `inj_data` is consumed in each of those cycles.
- R4: `grant_ring` gives the chosen ring index. Rings of the shorter direction are tried first: even rings when the even-direction distance is at most half the node count, otherwise odd rings. Within each parity, the lower index is tried first.
- R5: A ring is chosen only if none of the segments on its path is booked. A segment booked by a transfer that starts in cycle T+1 is freed once the last beat has left that segment's register.
- R6: Pending requests are scanned in round-robin order of source node, starting one past the most recently granted source.
- R7: A destination accepts no new grant while an earlier transfer to it has beats still to arrive. A denied request stays pending and is granted later without being presented again.
- R8: Words reach only their destination, in order and unchanged. An intermediate node's off-ramp stays quiet while words pass through it.
- R9: A request whose destination equals its source is never granted.
- R10: A node that is still feeding beats of an earlier grant is not granted again until its last beat has been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NODES | Request pending, one bit per source node |
| req_dst | input | NODES*ID_W | Destination node id per source |
| req_len | input | NODES*LEN_W | Beats minus one per source |
| grant | output | NODES | One-hot grant pulse by source node |
| grant_ring | output | RING_W | Ring assigned to the current grant |
| inj_take | output | NODES | On-ramp consumes `inj_data` of that node this cycle |
| inj_data | input | NODES*DATA_W | Outgoing word per node |
| ej_valid | output | NODES | Off-ramp word valid per node |
| ej_data | output | NODES*DATA_W | Off-ramp word per node |

## Verification
The embedded properties check on every cycle that grants are one-hot and go only to requesting, idle sources that do not target themselves. They also check that a booked segment or destination counts down undisturbed, that an injection never overwrites a word in transit, that a passing word is forwarded intact, and that no off-ramp sees two words at once. Only the bench's scenarios can show that the ring choice, the round-robin order, the arrival cycle and the payload match the requirements. These scenarios include heavy contention, a self-addressed request and a reset that cuts off transfers in flight, so that freed bookings are visible as an immediate grant.

// File: rtl/qrf_pkg.sv
package qrf_pkg;
    localparam int NODES     = 4;
    localparam int RINGS     = 4;
    localparam int DATA_W    = 128;
    localparam int MAX_BEATS = 16;

    localparam int ID_W   = (NODES > 1) ? $clog2(NODES) : 1;
    localparam int RING_W = (RINGS > 1) ? $clog2(RINGS) : 1;
    localparam int LEN_W  = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam int CNT_W  = $clog2(MAX_BEATS + NODES + 1);

    typedef logic [ID_W-1:0]   node_id_t;
    typedef logic [RING_W-1:0] ring_idx_t;
    typedef logic [CNT_W-1:0]  resv_cnt_t;

    typedef struct packed {
        logic              vld;
        node_id_t          dst;
        logic [DATA_W-1:0] data;
    } ring_word_t;

    // Node feeding node n on ring r.
    function automatic int upstream(int n, int r);
        return (r % 2 == 0) ? (n + NODES - 1) % NODES : (n + 1) % NODES;
    endfunction

    // Segment (register stage owner) j hops along from src.
    function automatic int seg_at(int src, int j, bit fwd);
        return fwd ? (src + j) % NODES : (src - j + NODES) % NODES;
    endfunction

    // k-th ring to try; preferred parity first, lower index first.
    function automatic int ring_pick(bit prefer_even, int k);
        int half;
        half = RINGS / 2;
        if (k < half) return 2 * k + (prefer_even ? 0 : 1);
        return 2 * (k - half) + (prefer_even ? 1 : 0);
    endfunction
endpackage

// File: rtl/qrf_node.sv
module qrf_node
    import qrf_pkg::*;
#(
    parameter int NODE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ring_word_t        ring_in  [RINGS],
    output ring_word_t        ring_out [RINGS],
    input  logic              grant_i,
    input  ring_idx_t         grant_ring_i,
    input  node_id_t          req_dst_i,
    input  logic [LEN_W-1:0]  req_len_i,
    input  logic [DATA_W-1:0] inj_data_i,
    output logic              inj_take_o,
    output logic              busy_o,
    output logic              ej_valid_o,
    output logic [DATA_W-1:0] ej_data_o
);
    localparam node_id_t ME = node_id_t'(NODE_ID);

    typedef struct packed {
        logic [LEN_W:0]              left;
        ring_idx_t                   ring;
        node_id_t                    dst;
        ring_word_t [RINGS-1:0]      stage;
    } node_state_t;

    node_state_t       st_d, st_q;
    logic [RINGS-1:0]  hit;
    logic [RINGS-1:0]  clash;
    logic              inject;

    always_comb begin
        st_d      = st_q;
        hit       = '0;
        clash     = '0;
        ej_data_o = '0;
        inject    = (st_q.left != '0);
        for (int r = 0; r < RINGS; r++) begin
            if (ring_in[r].vld && ring_in[r].dst == ME) begin
                hit[r]    = 1'b1;
                ej_data_o = ej_data_o | ring_in[r].data;
            end
            if (inject && st_q.ring == ring_idx_t'(r)) begin
                st_d.stage[r] = '{vld: 1'b1, dst: st_q.dst, data: inj_data_i};
                clash[r]      = ring_in[r].vld && ring_in[r].dst != ME;
            end else if (ring_in[r].vld && ring_in[r].dst != ME) begin
                st_d.stage[r] = ring_in[r];
            end else begin
                st_d.stage[r] = '0;
            end
        end
        if (inject) st_d.left = st_q.left - 1'b1;
        if (grant_i) begin
            st_d.left = {1'b0, req_len_i} + 1'b1;
            st_d.ring = grant_ring_i;
            st_d.dst  = req_dst_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int r = 0; r < RINGS; r++) ring_out[r] = st_q.stage[r];
    end

    assign inj_take_o = inject;
    assign busy_o     = inject;
    assign ej_valid_o = |hit;

    // R5: a booked path means an injection never lands on a word in transit
    p_no_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clash == '0);
    // R7: one transfer per destination, so at most one word arrives per cycle
    p_single_eject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R10: grants only reach an idle on-ramp
    p_grant_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> !busy_o);
    // R3: feeding starts the cycle after the grant
    p_take_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> inj_take_o);

    for (genvar r = 0; r < RINGS; r++) begin : g_pass_chk
        // R8: a word not for this node leaves the stage untouched
        p_pass_intact_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ring_in[r].vld && ring_in[r].dst != ME)
            |=> ring_out[r] == $past(ring_in[r]));
    end
endmodule

// File: rtl/qrf_ctrl.sv
module qrf_ctrl
    import qrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODES-1:0]  req_valid_i,
    input  node_id_t          req_dst_i [NODES],
    input  logic [LEN_W-1:0]  req_len_i [NODES],
    input  logic [NODES-1:0]  src_busy_i,
    output logic [NODES-1:0]  grant_o,
    output ring_idx_t         grant_ring_o
);
    typedef struct packed {
        resv_cnt_t [RINGS-1:0][NODES-1:0] seg;
        resv_cnt_t [NODES-1:0]            dst;
        node_id_t                         rr;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic      found, free;
    int        s, d, cw, r, hops, beats;
    int        win_src, win_dst, win_ring, win_hops;
    node_id_t  si, di;
    ring_idx_t ri;

    always_comb begin
        st_d         = st_q;
        grant_o      = '0;
        grant_ring_o = '0;
        found        = 1'b0;
        free         = 1'b0;
        s = 0; d = 0; cw = 0; r = 0; hops = 0; beats = 0;
        win_src = 0; win_dst = 0; win_ring = 0; win_hops = 0;
        si = '0; di = '0; ri = '0;

        for (int rg = 0; rg < RINGS; rg++)
            for (int n = 0; n < NODES; n++)
                if (st_q.seg[rg][n] != '0) st_d.seg[rg][n] = st_q.seg[rg][n] - 1'b1;
        for (int n = 0; n < NODES; n++)
            if (st_q.dst[n] != '0) st_d.dst[n] = st_q.dst[n] - 1'b1;

        for (int i = 0; i < NODES; i++) begin
            s  = (int'(st_q.rr) + i) % NODES;
            si = node_id_t'(s);
            d  = int'(req_dst_i[si]);
            di = node_id_t'(d);
            cw = (d - s + NODES) % NODES;
            if (!found && req_valid_i[si] && !src_busy_i[si] && cw != 0
                && st_q.dst[di] == '0) begin
                for (int k = 0; k < RINGS; k++) begin
                    r    = ring_pick(2 * cw <= NODES, k);
                    ri   = ring_idx_t'(r);
                    hops = (r % 2 == 0) ? cw : NODES - cw;
                    free = 1'b1;
                    for (int j = 0; j < NODES - 1; j++)
                        if (j < hops &&
                            st_q.seg[ri][node_id_t'(seg_at(s, j, r % 2 == 0))] != '0)
                            free = 1'b0;
                    if (!found && free) begin
                        found    = 1'b1;
                        win_src  = s;
                        win_dst  = d;
                        win_ring = r;
                        win_hops = hops;
                    end
                end
            end
        end

        if (found) begin
            si = node_id_t'(win_src);
            di = node_id_t'(win_dst);
            ri = ring_idx_t'(win_ring);
            grant_o[si]  = 1'b1;
            grant_ring_o = ri;
            st_d.rr      = node_id_t'((win_src + 1) % NODES);
            beats        = int'(req_len_i[si]) + 1;
            for (int j = 0; j < NODES - 1; j++)
                if (j < win_hops)
                    st_d.seg[ri][node_id_t'(seg_at(win_src, j, win_ring % 2 == 0))] =
                        resv_cnt_t'(j + beats + 1);
            st_d.dst[di] = resv_cnt_t'(win_hops + beats);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: at most one grant per cycle
    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    // R6: grants only go to requesting sources
    p_grant_has_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_valid_i) == '0);

    for (genvar n = 0; n < NODES; n++) begin : g_node_chk
        // R9: no grant to a self-addressed request
        p_no_self_r9: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[n] |-> req_dst_i[n] != node_id_t'(n));
        // R7: a busy destination is not rebooked early
        p_dst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.dst[n] != '0 |=> st_q.dst[n] == $past(st_q.dst[n]) - resv_cnt_t'(1));
        for (genvar rg = 0; rg < RINGS; rg++) begin : g_seg_chk
            // R5: a booked segment only counts down until free
            p_seg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.seg[rg][n] != '0
                |=> st_q.seg[rg][n] == $past(st_q.seg[rg][n]) - resv_cnt_t'(1));
        end
    end
endmodule

// File: rtl/quad_ring_fabric.sv
module quad_ring_fabric
    import qrf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NODES-1:0]        req_valid,
    input  logic [NODES*ID_W-1:0]   req_dst,
    input  logic [NODES*LEN_W-1:0]  req_len,
    output logic [NODES-1:0]        grant,
    output logic [RING_W-1:0]       grant_ring,
    output logic [NODES-1:0]        inj_take,
    input  logic [NODES*DATA_W-1:0] inj_data,
    output logic [NODES-1:0]        ej_valid,
    output logic [NODES*DATA_W-1:0] ej_data
);
    node_id_t         dst_w   [NODES];
    logic [LEN_W-1:0] len_w   [NODES];
    logic [NODES-1:0] busy_w;
    ring_word_t       stage_w [NODES][RINGS];
    ring_word_t       feed_w  [NODES][RINGS];

    qrf_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_dst_i    (dst_w),
        .req_len_i    (len_w),
        .src_busy_i   (busy_w),
        .grant_o      (grant),
        .grant_ring_o (grant_ring)
    );

    for (genvar n = 0; n < NODES; n++) begin : g_node
        assign dst_w[n] = req_dst[n*ID_W +: ID_W];
        assign len_w[n] = req_len[n*LEN_W +: LEN_W];

        for (genvar r = 0; r < RINGS; r++) begin : g_feed
            localparam int UP = upstream(n, r);
            assign feed_w[n][r] = stage_w[UP][r];
        end

        qrf_node #(.NODE_ID(n)) u_node (
            .clk          (clk),
            .rst_n        (rst_n),
            .ring_in      (feed_w[n]),
            .ring_out     (stage_w[n]),
            .grant_i      (grant[n]),
            .grant_ring_i (grant_ring),
            .req_dst_i    (dst_w[n]),
            .req_len_i    (len_w[n]),
            .inj_data_i   (inj_data[n*DATA_W +: DATA_W]),
            .inj_take_o   (inj_take[n]),
            .busy_o       (busy_w[n]),
            .ej_valid_o   (ej_valid[n]),
            .ej_data_o    (ej_data[n*DATA_W +: DATA_W])
        );
    end
endmodule

// File: tb/quad_ring_fabric_tb_top.sv
module quad_ring_fabric_tb_top;
    import qrf_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [NODES-1:0]        req_valid;
    logic [NODES*ID_W-1:0]   req_dst;
    logic [NODES*LEN_W-1:0]  req_len;
    logic [NODES-1:0]        grant;
    logic [RING_W-1:0]       grant_ring;
    logic [NODES-1:0]        inj_take;
    logic [NODES*DATA_W-1:0] inj_data;
    logic [NODES-1:0]        ej_valid;
    logic [NODES*DATA_W-1:0] ej_data;

    always #4 clk = ~clk;

    quad_ring_fabric dut_i (.*);

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    // reference state, built from the requirements
    int m_seg [RINGS][NODES];
    int m_dst [NODES];
    int m_rem [NODES];
    int m_hops[NODES];
    int m_to  [NODES];
    int m_rr;
    bit                exp_v[NODES][64];
    logic [DATA_W-1:0] exp_d[NODES][64];
    // pending requests
    bit p_v  [NODES];
    int p_dst[NODES];
    int p_len[NODES];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int r = 0; r < RINGS; r++) for (int n = 0; n < NODES; n++) m_seg[r][n] = 0;
        for (int n = 0; n < NODES; n++) begin
            m_dst[n] = 0; m_rem[n] = 0; p_v[n] = 0; m_hops[n] = 0; m_to[n] = 0;
            for (int k = 0; k < 64; k++) exp_v[n][k] = 0;
        end
        m_rr = 0;
    endtask

    // which source wins this cycle, and on which ring
    function automatic void predict(output int g_src, output int g_ring, output int g_hops);
        g_src = -1; g_ring = 0; g_hops = 0;
        for (int i = 0; i < NODES; i++) begin
            int s, d, cw;
            bit pe;
            s = (m_rr + i) % NODES;
            d = p_dst[s];
            cw = (d - s + NODES) % NODES;
            pe = (2 * cw <= NODES);
            if (g_src < 0 && p_v[s] && m_rem[s] == 0 && cw != 0 && m_dst[d] == 0) begin
                for (int pass = 0; pass < 2; pass++) begin
                    for (int r = 0; r < RINGS; r++) begin
                        int want, h;
                        bit fwd, ok;
                        want = (pass == 0) ? (pe ? 0 : 1) : (pe ? 1 : 0);
                        fwd = (r % 2 == 0);
                        h = fwd ? cw : NODES - cw;
                        ok = 1;
                        for (int j = 0; j < h; j++)
                            if (m_seg[r][fwd ? (s + j) % NODES : (s - j + NODES) % NODES] != 0) ok = 0;
                        if (g_src < 0 && (r % 2) == want && ok) begin
                            g_src = s; g_ring = r; g_hops = h;
                        end
                    end
                end
            end
        end
    endfunction

    task automatic new_requests(int rate);
        for (int n = 0; n < NODES; n++)
            if (!p_v[n] && int'($urandom % 100) < rate) begin
                p_v[n]   = 1;
                p_dst[n] = (n + 1 + int'($urandom % (NODES - 1))) % NODES;
                p_len[n] = int'($urandom % MAX_BEATS);
            end
    endtask

    task automatic step(int rate);
        int gs, gr, gh, slot;
        logic [NODES-1:0] expg;
        @(negedge clk);
        for (int n = 0; n < NODES; n++) begin
            req_valid[n] = p_v[n];
            req_dst[n*ID_W +: ID_W] = node_id_t'(p_dst[n]);
            req_len[n*LEN_W +: LEN_W] = LEN_W'(p_len[n]);
            inj_data[n*DATA_W +: DATA_W] = DATA_W'({$urandom, $urandom, $urandom, $urandom});
        end
        #1;
        cyc++;
        predict(gs, gr, gh);
        expg = '0;
        if (gs >= 0) expg[gs] = 1'b1;
        chk(grant == expg, "R3 R5 R6 R7 R9 R10", "grant vector", DATA_W'(grant), DATA_W'(expg));
        if (gs >= 0)
            chk(int'(grant_ring) == gr, "R4", "ring choice", DATA_W'(grant_ring), DATA_W'(gr));
        for (int n = 0; n < NODES; n++) begin
            chk(inj_take[n] == (m_rem[n] != 0), "R3", "on-ramp take",
                DATA_W'(inj_take[n]), DATA_W'(m_rem[n] != 0));
            if (m_rem[n] != 0) begin
                slot = (cyc + m_hops[n]) % 64;
                exp_v[m_to[n]][slot] = 1;
                exp_d[m_to[n]][slot] = inj_data[n*DATA_W +: DATA_W];
            end
        end
        slot = cyc % 64;
        for (int n = 0; n < NODES; n++) begin
            chk(ej_valid[n] == exp_v[n][slot], "R2 R8", "off-ramp valid",
                DATA_W'(ej_valid[n]), DATA_W'(exp_v[n][slot]));
            if (exp_v[n][slot])
                chk(ej_data[n*DATA_W +: DATA_W] == exp_d[n][slot], "R8", "off-ramp data",
                    ej_data[n*DATA_W +: DATA_W], exp_d[n][slot]);
            exp_v[n][slot] = 0;
        end
        for (int r = 0; r < RINGS; r++) for (int n = 0; n < NODES; n++)
            if (m_seg[r][n] != 0) m_seg[r][n]--;
        for (int n = 0; n < NODES; n++) begin
            if (m_dst[n] != 0) m_dst[n]--;
            if (m_rem[n] != 0) m_rem[n]--;
        end
        if (gs >= 0) begin
            for (int j = 0; j < gh; j++)
                m_seg[gr][(gr % 2 == 0) ? (gs + j) % NODES : (gs - j + NODES) % NODES] = j + p_len[gs] + 2;
            m_dst[p_dst[gs]] = gh + p_len[gs] + 1;
            m_rem[gs] = p_len[gs] + 1;
            m_hops[gs] = gh;
            m_to[gs] = p_dst[gs];
            m_rr = (gs + 1) % NODES;
            p_v[gs] = 0;
        end
        new_requests(rate);
    endtask

    task automatic do_reset(int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0;
        clear_model();
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            #1;
            chk(grant == '0, "R1", "grant in reset", DATA_W'(grant), '0);
            chk(inj_take == '0, "R1", "take in reset", DATA_W'(inj_take), '0);
            chk(ej_valid == '0, "R1", "off-ramp in reset", DATA_W'(ej_valid), '0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h51ce));
        rst_n = 1'b0; req_valid = '0; req_dst = '0; req_len = '0; inj_data = '0;
        clear_model();
        do_reset(3);

        // directed: R1 first request after reset granted at once, shortest direction
        p_v[0] = 1; p_dst[0] = 1; p_len[0] = 15;
        p_v[3] = 1; p_dst[3] = 2; p_len[3] = 3;
        for (int i = 0; i < 30; i++) step(0);

        // directed: R9 self-addressed request never granted
        p_v[1] = 1; p_dst[1] = 1; p_len[1] = 2;
        for (int i = 0; i < 12; i++) begin
            step(0);
            chk(grant[1] == 1'b0, "R9", "self request", DATA_W'(grant[1]), '0);
            p_v[1] = 1; p_dst[1] = 1;
        end
        p_v[1] = 0;

        // directed: R5 R7 all nodes at once to the same far destination
        for (int n = 0; n < NODES; n++) begin
            p_v[n] = (n != 2); p_dst[n] = 2; p_len[n] = 15;
        end
        for (int i = 0; i < 90; i++) step(0);

        // random traffic, light then heavy
        for (int i = 0; i < 1500; i++) step(30);
        for (int i = 0; i < 1500; i++) step(90);

        // R1: reset in the middle of traffic clears bookings
        do_reset(2);
        for (int n = 0; n < NODES; n++) begin
            p_v[n] = 1; p_dst[n] = (n + 2) % NODES; p_len[n] = 7;
        end
        step(0);
        chk(grant != '0, "R1", "grant right after reset", DATA_W'(grant), 1);
        for (int i = 0; i < 800; i++) step(60);
        for (int i = 0; i < 200; i++) step(0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule